// File: doc/BRIEF.md
# Four-Channel DMA Address Sequencer

This block keeps the per-channel control state of a four-channel DMA engine. Two control registers are held here, and the processor can write and read both of them. The first register gives each channel a data-bus choice and a transfer direction. The second register gives each channel an interrupt enable, an interrupt-pending flag, a reload mode and an address-step enable. For every channel the block also holds a current address, a reload (base) address and a transfer counter. These are loaded through a small load port.

The surrounding engine pulses a per-channel transfer-done strobe each time a transfer finishes. On that strobe the block does three things for the channel. It advances the current address according to the mode bits. It counts the transfer counter down. When the strobe finds the counter already at zero, it raises the channel's pending flag. Interrupt requests go out only while an external pending-enable input is high. A channel whose bus choice holds the reserved code reports an error and ignores its strobes. Bus cycles, arbitration between channels and the memory itself are handled elsewhere.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, both control registers read zero, and every current address, reload address and counter is zero.
- R2: In the bus/direction register, channel i uses bits [4i+1:4i] as the bus code (00 X, 01 Y, 10 I, 11 reserved) and bit 4i+2 as the direction (1 read, 0 write). Bit 4i+3 always reads zero. The `bus_sel` and `rd_dir` outputs follow the stored fields.
- R3: In the mode register, channel i uses bit 4i as the interrupt enable, 4i+1 as the pending flag, 4i+2 as the reload mode and 4i+3 as the address-step enable. A write stores all four bits.
- R4: When the address-step enable is 0, a transfer-done strobe leaves the current address unchanged.
- R5: When step enable is 1 and reload mode is 0, each strobe adds one to the current address. The address wraps modulo 2^AW.
- R6: When step enable is 1 and reload mode is 1, a strobe that finds the counter at zero copies the reload address into the current address. Otherwise the strobe adds one to the current address.
- R7: Each strobe decrements a nonzero counter by one. A counter at zero stays at zero.
- R8: A strobe that finds the counter at zero sets the channel's pending flag.
- R9: `irq[i]` is high exactly when the channel's pending flag, its interrupt enable and `pend_en` are all high.
- R10: Writing 0 to a pending bit clears it. If a set event occurs in the same cycle, the set wins.
- R11: A channel whose bus code is 11 drives `bus_err[i]` high, and its strobes change no address, counter or pending flag.
- R12: The load port writes the current address (`ld_sel`=0), the reload address (1) or the counter (2) of channel `ld_ch`. Code 3 does nothing. A load to a channel cancels that channel's strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_we | input | 1 | Write strobe for the bus/direction register |
| aic_we | input | 1 | Write strobe for the mode register |
| cfg_wdata | input | 4*NCH | Register write data |
| gen_rdata | output | 4*NCH | Bus/direction register contents |
| aic_rdata | output | 4*NCH | Mode register contents |
| ld_we | input | 1 | Load-port write strobe |
| ld_ch | input | clog2(NCH) | Channel targeted by the load |
| ld_sel | input | 2 | Load target: 0 current, 1 reload, 2 counter, 3 none |
| ld_data | input | DW | Load value |
| pend_en | input | 1 | External qualifier for interrupt requests |
| xfer_done | input | NCH | Per-channel transfer-done strobes |
| cur_addr | output | NCH*AW | Current addresses, channel i at [i*AW +: AW] |
| xfer_cnt | output | NCH*CW | Counters, channel i at [i*CW +: CW] |
| bus_sel | output | 2*NCH | Bus code per channel |
| rd_dir | output | NCH | Direction per channel, 1 = read |
| bus_err | output | NCH | Reserved bus code selected |
| irq | output | NCH | Qualified interrupt requests |

## Verification
The checker watches every cycle for the following: a frozen address when stepping is off, the unit step in increment mode, the countdown and the fact that counters never rise without a load, the pending flag being set by an exhausted counter, an error channel staying inert, zero reserved bits, and interrupt requests that always carry their qualifiers. Other behaviour needs a chosen sequence, and only the bench scenarios can show it. That covers the reload copy from the base address, address wrap, a set event winning over a clearing write, a load pre-empting a strobe, and the exact mapping of bus codes onto the outputs.

// File: rtl/dma_seq_pkg.sv
// Shared encodings for the DMA address sequencer.
package dma_seq_pkg;
    // Data-bus selection codes held in the low two bits of each bus/direction nibble.
    typedef enum logic [1:0] {
        BUS_X    = 2'b00,
        BUS_Y    = 2'b01,
        BUS_I    = 2'b10,
        BUS_RSVD = 2'b11
    } bus_e;

    // Load-port target codes.
    typedef enum logic [1:0] {
        LD_CUR  = 2'd0,
        LD_BASE = 2'd1,
        LD_CNT  = 2'd2,
        LD_NONE = 2'd3
    } ld_e;

    // Mode nibble, most significant bit first.
    typedef struct packed {
        logic step_en;
        logic reload_mode;
        logic pend;
        logic irq_en;
    } mode_nib_t;
endpackage

// File: rtl/dma_seq_regs.sv
// Control register pair. One register holds the bus/direction fields, the other the mode nibbles.
// Assumes: reserved bit 4i+3 of the bus/direction register is never stored.
// A pending set event overrides a same-cycle write to that pending bit.
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int RW  = 4 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gen_we,
    input  logic           aic_we,
    input  logic [RW-1:0]  wdata,
    input  logic [NCH-1:0] pend_set,
    output logic [RW-1:0]  gen_q,
    output logic [RW-1:0]  aic_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [2:0] gen_nib_q;
        mode_nib_t  mode_q;
        mode_nib_t  mode_w;

        // Stores the bus code and direction of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)      gen_nib_q <= '0;
            else if (gen_we) gen_nib_q <= wdata[4*i +: 3];
        end

        assign mode_w = mode_nib_t'(wdata[4*i +: 4]);

        // Stores the mode nibble; a pending set event has priority over the write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q <= '0;
            end else begin
                if (aic_we) begin
                    mode_q.step_en     <= mode_w.step_en;
                    mode_q.reload_mode <= mode_w.reload_mode;
                    mode_q.irq_en      <= mode_w.irq_en;
                end
                mode_q.pend <= pend_set[i] | (aic_we ? mode_w.pend : mode_q.pend);
            end
        end

        assign gen_q[4*i +: 4] = {1'b0, gen_nib_q};
        assign aic_q[4*i +: 4] = mode_q;
    end
endmodule

// File: rtl/dma_seq_chan.sv
// One channel's address and count state.
// A load addressed to this channel cancels the strobe of the same cycle.
// Assumes DW >= AW and DW >= CW.
module dma_seq_chan
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic          blocked,
    input  logic          step_en,
    input  logic          reload_mode,
    input  logic          ld_hit,
    input  ld_e           ld_sel,
    input  logic [DW-1:0] ld_data,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          pend_set
);
    logic [AW-1:0] base_q;
    logic          step;
    logic          cnt_zero;

    assign step     = done & ~blocked & ~ld_hit;
    assign cnt_zero = (cnt_q == '0);
    assign pend_set = step & cnt_zero;

    // Holds the reload address.
    always_ff @(posedge clk) begin
        if (!rst_n)                           base_q <= '0;
        else if (ld_hit && ld_sel == LD_BASE) base_q <= ld_data[AW-1:0];
    end

    // Advances, reloads or loads the current address.
    always_ff @(posedge clk) begin
        if (!rst_n)                          addr_q <= '0;
        else if (ld_hit && ld_sel == LD_CUR) addr_q <= ld_data[AW-1:0];
        else if (step && step_en)            addr_q <= (reload_mode && cnt_zero) ? base_q : addr_q + 1'b1;
    end

    // Counts transfers down to zero and holds there.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (ld_hit && ld_sel == LD_CNT) cnt_q <= ld_data[CW-1:0];
        else if (step && !cnt_zero)          cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/dma_addr_seq.sv
// Top of the DMA address sequencer. It joins the control registers with one channel unit per channel.
// It decodes the bus code and direction, flags reserved bus codes and qualifies the interrupts.
// Assumes NCH >= 2 and at most one load per cycle.
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DW  = (AW > CW) ? AW : CW,
    parameter int RW  = 4 * NCH,
    parameter int CHW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_we,
    input  logic               aic_we,
    input  logic [RW-1:0]      cfg_wdata,
    output logic [RW-1:0]      gen_rdata,
    output logic [RW-1:0]      aic_rdata,
    input  logic               ld_we,
    input  logic [CHW-1:0]     ld_ch,
    input  logic [1:0]         ld_sel,
    input  logic [DW-1:0]      ld_data,
    input  logic               pend_en,
    input  logic [NCH-1:0]     xfer_done,
    output logic [NCH*AW-1:0]  cur_addr,
    output logic [NCH*CW-1:0]  xfer_cnt,
    output logic [2*NCH-1:0]   bus_sel,
    output logic [NCH-1:0]     rd_dir,
    output logic [NCH-1:0]     bus_err,
    output logic [NCH-1:0]     irq
);
    logic [NCH-1:0] pend_set;
    ld_e            ld_kind;

    assign ld_kind = ld_e'(ld_sel);

    dma_seq_regs #(.NCH(NCH), .RW(RW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_we   (gen_we),
        .aic_we   (aic_we),
        .wdata    (cfg_wdata),
        .pend_set (pend_set),
        .gen_q    (gen_rdata),
        .aic_q    (aic_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        mode_nib_t mode;
        bus_e      bus;
        logic      ld_hit;

        assign mode   = mode_nib_t'(aic_rdata[4*i +: 4]);
        assign bus    = bus_e'(gen_rdata[4*i +: 2]);
        assign ld_hit = ld_we && (ld_ch == CHW'(i)) && (ld_kind != LD_NONE);

        assign bus_sel[2*i +: 2] = bus;
        assign rd_dir[i]         = gen_rdata[4*i+2];
        assign bus_err[i]        = (bus == BUS_RSVD);
        assign irq[i]            = mode.pend & mode.irq_en & pend_en;

        dma_seq_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .done        (xfer_done[i]),
            .blocked     (bus_err[i]),
            .step_en     (mode.step_en),
            .reload_mode (mode.reload_mode),
            .ld_hit      (ld_hit),
            .ld_sel      (ld_kind),
            .ld_data     (ld_data),
            .addr_q      (cur_addr[i*AW +: AW]),
            .cnt_q       (xfer_cnt[i*CW +: CW]),
            .pend_set    (pend_set[i])
        );
    end
endmodule

// File: rtl/dma_seq_chk.sv
// Checker for the DMA address sequencer. It looks only at top-level ports.
module dma_seq_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int RW  = 4 * NCH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_we,
    input logic              pend_en,
    input logic [NCH-1:0]    xfer_done,
    input logic [NCH*AW-1:0] cur_addr,
    input logic [NCH*CW-1:0] xfer_cnt,
    input logic [RW-1:0]     gen_rdata,
    input logic [RW-1:0]     aic_rdata,
    input logic [NCH-1:0]    rd_dir,
    input logic [NCH-1:0]    bus_err,
    input logic [NCH-1:0]    irq
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
            gen_rdata[4*i+3] == 1'b0);
        a_r2_dir_field: assert property (@(posedge clk) disable iff (!rst_n)
            rd_dir[i] == gen_rdata[4*i+2]);
        a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_done[i] && !aic_rdata[4*i+3] && !ld_we)
            |=> $stable(cur_addr[i*AW +: AW]));
        a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_done[i] && !bus_err[i] && !ld_we && aic_rdata[4*i+3]
             && (!aic_rdata[4*i+2] || xfer_cnt[i*CW +: CW] != '0))
            |=> cur_addr[i*AW +: AW] == $past(cur_addr[i*AW +: AW]) + AW'(1));
        a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_done[i] && !bus_err[i] && !ld_we && xfer_cnt[i*CW +: CW] != '0)
            |=> xfer_cnt[i*CW +: CW] == $past(xfer_cnt[i*CW +: CW]) - CW'(1));
        a_r7_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_we |=> xfer_cnt[i*CW +: CW] <= $past(xfer_cnt[i*CW +: CW]));
        a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_done[i] && !bus_err[i] && !ld_we && xfer_cnt[i*CW +: CW] == '0)
            |=> aic_rdata[4*i+1]);
        a_r9_irq_qual: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (pend_en && aic_rdata[4*i] && aic_rdata[4*i+1]));
        a_r11_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
            bus_err[i] == (gen_rdata[4*i +: 2] == 2'b11));
        a_r11_err_inert: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_done[i] && bus_err[i] && !ld_we)
            |=> ($stable(cur_addr[i*AW +: AW]) && $stable(xfer_cnt[i*CW +: CW])));
    end
endmodule

bind dma_addr_seq dma_seq_chk #(.NCH(NCH), .AW(AW), .CW(CW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_we     (ld_we),
    .pend_en   (pend_en),
    .xfer_done (xfer_done),
    .cur_addr  (cur_addr),
    .xfer_cnt  (xfer_cnt),
    .gen_rdata (gen_rdata),
    .aic_rdata (aic_rdata),
    .rd_dir    (rd_dir),
    .bus_err   (bus_err),
    .irq       (irq)
);

// File: tb/test_dma_addr_seq.sv
// Directed bench: one task per scenario, each task checking its own results.
module test_dma_addr_seq;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              gen_we = 1'b0, aic_we = 1'b0, ld_we = 1'b0, pend_en = 1'b0;
    logic [15:0]       cfg_wdata = '0, ld_data = '0;
    logic [1:0]        ld_ch = '0, ld_sel = '0;
    logic [NCH-1:0]    xfer_done = '0;
    logic [15:0]       gen_rdata, aic_rdata;
    logic [NCH*AW-1:0] cur_addr;
    logic [NCH*CW-1:0] xfer_cnt;
    logic [7:0]        bus_sel;
    logic [NCH-1:0]    rd_dir, bus_err, irq;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    dma_addr_seq i_dma_addr_seq (
        .clk(clk), .rst_n(rst_n), .gen_we(gen_we), .aic_we(aic_we),
        .cfg_wdata(cfg_wdata), .gen_rdata(gen_rdata), .aic_rdata(aic_rdata),
        .ld_we(ld_we), .ld_ch(ld_ch), .ld_sel(ld_sel), .ld_data(ld_data),
        .pend_en(pend_en), .xfer_done(xfer_done), .cur_addr(cur_addr),
        .xfer_cnt(xfer_cnt), .bus_sel(bus_sel), .rd_dir(rd_dir),
        .bus_err(bus_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] addr_of(input int ch);
        return cur_addr[ch*AW +: AW];
    endfunction

    function automatic logic [15:0] cnt_of(input int ch);
        return xfer_cnt[ch*CW +: CW];
    endfunction

    task automatic wr_gen(input logic [15:0] d);
        @(negedge clk); gen_we = 1'b1; cfg_wdata = d;
        @(negedge clk); gen_we = 1'b0;
    endtask

    task automatic wr_aic(input logic [15:0] d);
        @(negedge clk); aic_we = 1'b1; cfg_wdata = d;
        @(negedge clk); aic_we = 1'b0;
    endtask

    task automatic load(input int ch, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); ld_we = 1'b1; ld_ch = 2'(ch); ld_sel = sel; ld_data = d;
        @(negedge clk); ld_we = 1'b0;
    endtask

    task automatic strobe(input logic [NCH-1:0] m);
        @(negedge clk); xfer_done = m;
        @(negedge clk); xfer_done = '0;
    endtask

    task automatic t_reset;
        check("R1 bus/dir reg", 32'(gen_rdata), 32'h0);
        check("R1 mode reg", 32'(aic_rdata), 32'h0);
        check("R1 addresses", 32'(cur_addr[31:0] | cur_addr[63:32]), 32'h0);
        check("R1 counters", 32'(xfer_cnt[31:0] | xfer_cnt[63:32]), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_fields;
        wr_gen(16'hFFFF);
        check("R2 reserved bits read zero", 32'(gen_rdata), 32'h7777);
        check("R11 err on code 11", 32'(bus_err), 32'hF);
        wr_gen(16'h6521);
        check("R2 bus codes", 32'(bus_sel), 32'h99);
        check("R2 direction", 32'(rd_dir), 32'hC);
        check("R2 no err", 32'(bus_err), 32'h0);
        wr_aic(16'hFFFF);
        check("R3 mode write all bits", 32'(aic_rdata), 32'hFFFF);
        wr_aic(16'h0000);
        check("R3 mode clear", 32'(aic_rdata), 32'h0);
        wr_gen(16'h0000);
    endtask

    task automatic t_hold;
        load(1, 2'd2, 16'd5);
        load(1, 2'd0, 16'h1234);
        strobe(4'b0010);
        check("R4 address frozen", 32'(addr_of(1)), 32'h1234);
        check("R7 count 5->4", 32'(cnt_of(1)), 32'd4);
    endtask

    task automatic t_incr;
        wr_aic(16'h0800);
        load(2, 2'd0, 16'hFFFF);
        load(2, 2'd2, 16'd3);
        strobe(4'b0100);
        check("R5 wrap to zero", 32'(addr_of(2)), 32'h0000);
        strobe(4'b0100);
        check("R5 increment", 32'(addr_of(2)), 32'h0001);
        check("R7 count 3->1", 32'(cnt_of(2)), 32'd1);
    endtask

    task automatic t_reload;
        wr_aic(16'hC000);
        load(3, 2'd1, 16'h0100);
        load(3, 2'd0, 16'h0200);
        load(3, 2'd2, 16'd1);
        strobe(4'b1000);
        check("R6 nonzero count increments", 32'(addr_of(3)), 32'h0201);
        check("R7 count 1->0", 32'(cnt_of(3)), 32'd0);
        strobe(4'b1000);
        check("R6 zero count reloads", 32'(addr_of(3)), 32'h0100);
        check("R8 pending ch3", 32'(aic_rdata), 32'hE000);
        wr_aic(16'hC000);
        check("R10 pending cleared", 32'(aic_rdata), 32'hC000);
        wr_aic(16'h0000);
    endtask

    task automatic t_count;
        load(0, 2'd2, 16'd2);
        strobe(4'b0001);
        strobe(4'b0001);
        check("R7 count reaches zero", 32'(cnt_of(0)), 32'd0);
        check("R8 no pending yet", 32'(aic_rdata[1]), 32'd0);
        strobe(4'b0001);
        check("R7 stays at zero", 32'(cnt_of(0)), 32'd0);
        check("R8 pending on exhausted strobe", 32'(aic_rdata[1]), 32'd1);
    endtask

    task automatic t_irq;
        wr_aic(16'h0003);
        pend_en = 1'b0; #1;
        check("R9 irq gated by pend_en", 32'(irq), 32'h0);
        pend_en = 1'b1; #1;
        check("R9 irq asserted", 32'(irq), 32'h1);
        wr_aic(16'h0002);
        check("R9 irq gated by enable", 32'(irq), 32'h0);
        wr_aic(16'h0000);
        check("R10 write zero clears", 32'(aic_rdata), 32'h0);
        pend_en = 1'b0;
    endtask

    task automatic t_set_wins;
        @(negedge clk); aic_we = 1'b1; cfg_wdata = 16'h0000; xfer_done = 4'b0001;
        @(negedge clk); aic_we = 1'b0; xfer_done = '0;
        check("R10 set wins over clear", 32'(aic_rdata), 32'h0002);
        wr_aic(16'h0000);
    endtask

    task automatic t_reserved;
        wr_gen(16'h0003);
        check("R11 err ch0 only", 32'(bus_err), 32'h1);
        wr_aic(16'h0008);
        load(0, 2'd0, 16'h0050);
        load(0, 2'd2, 16'd2);
        strobe(4'b0001);
        check("R11 addr ignored", 32'(addr_of(0)), 32'h0050);
        check("R11 count ignored", 32'(cnt_of(0)), 32'd2);
        check("R11 pending untouched", 32'(aic_rdata), 32'h0008);
        wr_gen(16'h0000);
        strobe(4'b0001);
        check("R11 resumes after code change", 32'(addr_of(0)), 32'h0051);
    endtask

    task automatic t_load_prio;
        wr_aic(16'h0080);
        load(1, 2'd3, 16'hBEEF);
        check("R12 code 3 no effect", 32'(addr_of(1)), 32'h1234);
        @(negedge clk); ld_we = 1'b1; ld_ch = 2'd1; ld_sel = 2'd0; ld_data = 16'h0500; xfer_done = 4'b0010;
        @(negedge clk); ld_we = 1'b0; xfer_done = '0;
        check("R12 load wins over strobe", 32'(addr_of(1)), 32'h0500);
        check("R12 strobe cancelled", 32'(cnt_of(1)), 32'd4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_hold();
        t_incr();
        t_reload();
        t_count();
        t_irq();
        t_set_wins();
        t_reserved();
        t_load_prio();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule